// File: doc/BRIEF.md
# Floppy Data-Rate and Write-Precompensation Control

This block is the host-writable 8-bit rate/control register of a floppy disk controller, together with the logic it drives. A host write can fire a one-cycle software reset, put the controller into a manual low-power state, pick the data rate, and pick the write-precompensation delay. The block runs on a 24 MHz clock. One clock period is the 41.7 ns precompensation step, so every delay is a whole number of cycles.

The precompensation unit delays each raw write-data pulse by 0 to 6 clock cycles. The delay is zero while the current track is below a configurable starting track. Code 000 does not set a fixed delay: it selects a default that depends on the data rate. Manual power-down holds the controller clock enable low. It ends on a software reset, or on an access to the data FIFO or to the main status register. A software reset changes nothing in the register except the power-down state.

Top module: `fdc_rate_ctrl`

## Requirements
- R1: After reset, `reg_rdata` is 8'h02: rate 250 Kbps, precompensation code 000, power-down clear. `clk_en` is 1 and `sw_reset_pulse` is 0.
- R2: A write with bit 7 set drives `sw_reset_pulse` high for exactly the one cycle after the write. Bit 7 always reads back as 0, and the other fields of that write are stored.
- R3: A write with bit 6 set and bit 7 clear enters power-down. `clk_en` goes low in the cycle after the write, and read-back bit 6 is 1. If bit 7 is also set, the reset wins and power-down is not entered.
- R4: Power-down ends, with `clk_en` high in the next cycle, on a `fifo_acc` pulse, on a `msr_acc` pulse, or on a write with bit 7 set. An access in the same cycle as a power-down write wins, so the block stays awake.
- R5: Bits 1:0 select the rate on `rate_sel`: 00 is 500 Kbps, 01 is 300 Kbps, 10 is 250 Kbps and 11 is 1 Mbps. Bit 5 is ignored and reads 0.
- R6: Bits 4:2 are the precompensation code. Code 111 gives 0 cycles, and codes 001 to 110 give 1 to 6 cycles, shown on `precomp_cycles`.
- R7: Code 000 gives 1 cycle when the rate is 1 Mbps (11), and 3 cycles at the other three rates.
- R8: While `cur_track` < `start_track`, `precomp_cycles` is 0. When `cur_track` is equal to or above `start_track`, the delay set by the code applies.
- R9: `wdata_out` is `wdata_in` delayed by `precomp_cycles` clock cycles. A delay of 0 passes the pulse through in the same cycle.
- R10: While powered down, a write with bits 7 and 6 both clear does not wake the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24 MHz controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read-back value |
| fifo_acc | input | 1 | Data FIFO access strobe |
| msr_acc | input | 1 | Main status register access strobe |
| cur_track | input | 8 | Current track number |
| start_track | input | 8 | Track at which precompensation starts |
| wdata_in | input | 1 | Raw write-data pulse |
| wdata_out | output | 1 | Precompensated write-data pulse |
| sw_reset_pulse | output | 1 | One-cycle software reset |
| clk_en | output | 1 | Controller clock enable (low in power-down) |
| rate_sel | output | 2 | Selected data rate code |
| precomp_cycles | output | 3 | Delay now applied, in clock cycles |

## Verification
Two actions can land in the same cycle: a write that enters power-down, and a wake event. The wake event is either a FIFO or status access, or bit 7 in the same write. The bench drives a power-down write in the same cycle as a FIFO access, and also writes bit 7 and bit 6 together. In both cases it expects `clk_en` to stay high in the following cycle and read-back bit 6 to be 0. In the second case it also expects the reset pulse.

// File: rtl/fdc_rate_pkg.sv
// Package: shared encodings for the floppy rate/precompensation control.
// Assumes a 24 MHz clock, so one cycle equals one 41.7 ns precompensation step.
package fdc_rate_pkg;
    typedef enum logic [1:0] {
        RATE_500K = 2'b00,
        RATE_300K = 2'b01,
        RATE_250K = 2'b10,
        RATE_1M   = 2'b11
    } rate_e;

    localparam logic [2:0] PC_DEFAULT = 3'b000;
    localparam logic [2:0] PC_NONE    = 3'b111;
    localparam int unsigned DEF_FAST_CYC = 1;  // 41.7 ns at 1 Mbps
    localparam int unsigned DEF_SLOW_CYC = 3;  // 125 ns at the slower rates
endpackage

// File: rtl/fdc_rate_reg.sv
// Module: stores the rate and precompensation fields and makes the
// one-cycle software reset pulse. Assumes reg_wr is a single-cycle strobe.
module fdc_rate_reg
    import fdc_rate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic       rst_bit,
    input  logic [2:0] pc_in,
    input  logic [1:0] rate_in,
    output logic [2:0] pc_code,
    output rate_e      rate,
    output logic       sw_pulse
);
    // Capture the fields on a write; the reset pulse lasts one cycle only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_code  <= PC_DEFAULT;
            rate     <= RATE_250K;
            sw_pulse <= 1'b0;
        end else begin
            sw_pulse <= wr & rst_bit;
            if (wr) begin
                pc_code <= pc_in;
                rate    <= rate_e'(rate_in);
            end
        end
    end
endmodule

// File: rtl/fdc_pwr_ctrl.sv
// Module: manual power-down latch. It is set by a write with the power-down
// bit and woken by a FIFO or status access or a reset write. Wake has priority.
module fdc_pwr_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic rst_bit,
    input  logic pd_bit,
    input  logic fifo_acc,
    input  logic msr_acc,
    output logic pd
);
    logic wake;
    logic sleep;

    // Decode the wake and sleep events for this cycle.
    always_comb begin
        wake  = fifo_acc | msr_acc | (wr & rst_bit);
        sleep = wr & pd_bit;
    end

    // Hold the power-down state; a wake event overrides a sleep request.
    always_ff @(posedge clk) begin
        if (!rst_n)     pd <= 1'b0;
        else if (wake)  pd <= 1'b0;
        else if (sleep) pd <= 1'b1;
    end
endmodule

// File: rtl/fdc_precomp.sv
// Module: maps the code and rate to a cycle delay, gates it by track, and
// delays the write pulse through a shift register of MAX_DELAY stages.
// Assumes MAX_DELAY >= 6, so that every code can be reached.
module fdc_precomp
    import fdc_rate_pkg::*;
#(
    parameter int unsigned MAX_DELAY = 6,
    parameter int unsigned TRACK_W   = 8,
    localparam int unsigned DLY_W    = $clog2(MAX_DELAY + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         pc_code,
    input  rate_e              rate,
    input  logic [TRACK_W-1:0] cur_track,
    input  logic [TRACK_W-1:0] start_track,
    input  logic               din,
    output logic               dout,
    output logic [DLY_W-1:0]   dly
);
    logic [DLY_W-1:0]     raw;
    logic [MAX_DELAY-1:0] sr;

    // Translate the code (and the rate, for code 000) into a cycle count.
    always_comb begin
        case (pc_code)
            PC_DEFAULT: raw = (rate == RATE_1M) ? DLY_W'(DEF_FAST_CYC) : DLY_W'(DEF_SLOW_CYC);
            PC_NONE:    raw = '0;
            default:    raw = DLY_W'(pc_code);
        endcase
        dly = (cur_track >= start_track) ? raw : '0;
    end

    // Shift the raw pulse along one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[MAX_DELAY-2:0], din};
    end

    // Select the tap that matches the delay; delay 0 is a pass-through.
    always_comb begin
        dout = din;
        for (int i = 1; i <= MAX_DELAY; i++) begin
            if (dly == DLY_W'(i)) dout = sr[i-1];
        end
    end
endmodule

// File: rtl/fdc_rate_ctrl.sv
// Module: top level of the rate/precompensation control register.
// Read-back layout: [7]=0, [6]=power-down, [5]=0, [4:2]=code, [1:0]=rate.
module fdc_rate_ctrl
    import fdc_rate_pkg::*;
#(
    parameter int unsigned MAX_DELAY = 6,
    parameter int unsigned TRACK_W   = 8,
    localparam int unsigned DLY_W    = $clog2(MAX_DELAY + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic               fifo_acc,
    input  logic               msr_acc,
    input  logic [TRACK_W-1:0] cur_track,
    input  logic [TRACK_W-1:0] start_track,
    input  logic               wdata_in,
    output logic               wdata_out,
    output logic               sw_reset_pulse,
    output logic               clk_en,
    output logic [1:0]         rate_sel,
    output logic [DLY_W-1:0]   precomp_cycles
);
    logic [2:0] pc_code;
    rate_e      rate;
    logic       pd;

    fdc_rate_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rst_bit(reg_wdata[7]),
        .pc_in(reg_wdata[4:2]), .rate_in(reg_wdata[1:0]),
        .pc_code(pc_code), .rate(rate), .sw_pulse(sw_reset_pulse)
    );

    fdc_pwr_ctrl u_pwr (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rst_bit(reg_wdata[7]),
        .pd_bit(reg_wdata[6]), .fifo_acc(fifo_acc), .msr_acc(msr_acc), .pd(pd)
    );

    fdc_precomp #(.MAX_DELAY(MAX_DELAY), .TRACK_W(TRACK_W)) u_pc (
        .clk(clk), .rst_n(rst_n), .pc_code(pc_code), .rate(rate),
        .cur_track(cur_track), .start_track(start_track),
        .din(wdata_in), .dout(wdata_out), .dly(precomp_cycles)
    );

    // Drive the read-back value and the decoded outputs.
    always_comb begin
        reg_rdata = {1'b0, pd, 1'b0, pc_code, rate};
        clk_en    = ~pd;
        rate_sel  = rate;
    end
endmodule

// File: rtl/fdc_rate_ctrl_chk.sv
// Module: checker bound to fdc_rate_ctrl. Relates the port behaviour over time.
module fdc_rate_ctrl_chk #(
    parameter int unsigned MAX_DELAY = 6,
    parameter int unsigned TRACK_W   = 8,
    localparam int unsigned DLY_W    = $clog2(MAX_DELAY + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [7:0]         reg_wdata,
    input logic [7:0]         reg_rdata,
    input logic               fifo_acc,
    input logic               msr_acc,
    input logic [TRACK_W-1:0] cur_track,
    input logic [TRACK_W-1:0] start_track,
    input logic               wdata_in,
    input logic               wdata_out,
    input logic               sw_reset_pulse,
    input logic               clk_en,
    input logic [DLY_W-1:0]   precomp_cycles
);
    // R2: the reset pulse follows a bit-7 write and lasts a single cycle
    a_r2_pulse_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_wdata[7] |=> sw_reset_pulse);
    a_r2_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset_pulse |=> !sw_reset_pulse);
    a_r2_bit7_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7] == 1'b0);
    // R3: a plain power-down write drops the clock enable
    a_r3_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_wdata[6] && !reg_wdata[7] && !fifo_acc && !msr_acc |=> !clk_en);
    // R4: any access wakes the controller
    a_r4_wake: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_acc || msr_acc |=> clk_en);
    // R10: a write that neither resets nor sleeps leaves power-down alone
    a_r10_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en && reg_wr && !reg_wdata[7] && !reg_wdata[6] && !fifo_acc && !msr_acc |=> !clk_en);
    // R8: no delay below the starting track
    a_r8_below_start: assert property (@(posedge clk) disable iff (!rst_n)
        cur_track < start_track |-> precomp_cycles == '0);
    // R9: zero delay is a pass-through
    a_r9_pass: assert property (@(posedge clk) disable iff (!rst_n)
        precomp_cycles == '0 |-> wdata_out == wdata_in);
endmodule

bind fdc_rate_ctrl fdc_rate_ctrl_chk #(.MAX_DELAY(MAX_DELAY), .TRACK_W(TRACK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fifo_acc(fifo_acc), .msr_acc(msr_acc),
    .cur_track(cur_track), .start_track(start_track), .wdata_in(wdata_in),
    .wdata_out(wdata_out), .sw_reset_pulse(sw_reset_pulse), .clk_en(clk_en),
    .precomp_cycles(precomp_cycles)
);

// File: tb/fdc_rate_ctrl_bench.sv
module fdc_rate_ctrl_bench;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       reg_wr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       fifo_acc = 0;
    logic       msr_acc = 0;
    logic [7:0] cur_track = 8'd5;
    logic [7:0] start_track = 8'd0;
    logic       wdata_in = 0;
    logic       wdata_out;
    logic       sw_reset_pulse;
    logic       clk_en;
    logic [1:0] rate_sel;
    logic [2:0] precomp_cycles;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fdc_rate_ctrl u_fdc_rate_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .fifo_acc(fifo_acc), .msr_acc(msr_acc),
        .cur_track(cur_track), .start_track(start_track), .wdata_in(wdata_in),
        .wdata_out(wdata_out), .sw_reset_pulse(sw_reset_pulse), .clk_en(clk_en),
        .rate_sel(rate_sel), .precomp_cycles(precomp_cycles)
    );

    // Entry = {code[2:0], rate[1:0], expected cycles[2:0]} (R6, R7)
    localparam logic [7:0] VEC [32] = '{
        {3'd0,2'd0,3'd3},{3'd0,2'd1,3'd3},{3'd0,2'd2,3'd3},{3'd0,2'd3,3'd1},
        {3'd1,2'd0,3'd1},{3'd1,2'd1,3'd1},{3'd1,2'd2,3'd1},{3'd1,2'd3,3'd1},
        {3'd2,2'd0,3'd2},{3'd2,2'd1,3'd2},{3'd2,2'd2,3'd2},{3'd2,2'd3,3'd2},
        {3'd3,2'd0,3'd3},{3'd3,2'd1,3'd3},{3'd3,2'd2,3'd3},{3'd3,2'd3,3'd3},
        {3'd4,2'd0,3'd4},{3'd4,2'd1,3'd4},{3'd4,2'd2,3'd4},{3'd4,2'd3,3'd4},
        {3'd5,2'd0,3'd5},{3'd5,2'd1,3'd5},{3'd5,2'd2,3'd5},{3'd5,2'd3,3'd5},
        {3'd6,2'd0,3'd6},{3'd6,2'd1,3'd6},{3'd6,2'd2,3'd6},{3'd6,2'd3,3'd6},
        {3'd7,2'd0,3'd0},{3'd7,2'd1,3'd0},{3'd7,2'd2,3'd0},{3'd7,2'd3,3'd0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One-cycle write; on return the cycle after the write is being sampled.
    task automatic wr(input logic [7:0] d, input logic fa = 0);
        @(negedge clk);
        reg_wr = 1; reg_wdata = d; fifo_acc = fa;
        @(negedge clk);
        reg_wr = 0; fifo_acc = 0;
        #0.5;
    endtask

    // Send one pulse and return the number of cycles until it appears (-1 if lost).
    task automatic measure(output int dly);
        dly = -1;
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            wdata_in = (k == 0);
            #0.5;
            if (wdata_out && dly < 0) dly = k;
        end
        wdata_in = 0;
    endtask

    task automatic access(input bit use_msr);
        @(negedge clk);
        fifo_acc = !use_msr; msr_acc = use_msr;
        @(negedge clk);
        fifo_acc = 0; msr_acc = 0;
        #0.5;
    endtask

    initial begin
        int d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #0.5;
        // R1 reset state
        check("R1 rdata", reg_rdata, 8'h02);
        check("R1 clk_en", clk_en, 1);
        check("R1 pulse", sw_reset_pulse, 0);
        check("R5 reset rate", rate_sel, 2);

        // R6/R7/R9 table walk at every code and rate
        for (int i = 0; i < 32; i++) begin
            wr({3'b000, VEC[i][7:5], VEC[i][4:3]});
            check("R6/R7 precomp_cycles", precomp_cycles, VEC[i][2:0]);
            check("R5 rate_sel", rate_sel, VEC[i][4:3]);
            measure(d);
            check("R9 measured delay", d, VEC[i][2:0]);
        end

        // R5: bit 5 ignored and reads 0; bit 6 with bit 7 does not sleep (R3)
        wr(8'hFF);
        check("R5 R3 rdata after FF", reg_rdata, 8'h1F);
        check("R2 pulse after FF", sw_reset_pulse, 1);
        check("R3 reset wins, clk_en", clk_en, 1);
        @(negedge clk); #0.5;
        check("R2 pulse one cycle", sw_reset_pulse, 0);

        // R8 track gating with code 110
        wr(8'h18);
        start_track = 8'd10; cur_track = 8'd9; #0.5;
        check("R8 below start", precomp_cycles, 0);
        measure(d);
        check("R8 below start delay", d, 0);
        cur_track = 8'd10; #0.5;
        check("R8 at start", precomp_cycles, 6);
        measure(d);
        check("R8 at start delay", d, 6);
        cur_track = 8'd200; #0.5;
        check("R8 above start", precomp_cycles, 6);
        start_track = 8'd0; cur_track = 8'd5;

        // R3/R4 power-down and the three wake events
        wr(8'h42);
        check("R3 sleep clk_en", clk_en, 0);
        check("R3 sleep rdata6", reg_rdata[6], 1);
        wr(8'h02);
        check("R10 plain write no wake", clk_en, 0);
        access(0);
        check("R4 wake on fifo", clk_en, 1);
        wr(8'h42);
        access(1);
        check("R4 wake on msr", clk_en, 1);
        wr(8'h42);
        wr(8'h82);
        check("R4 wake on reset write", clk_en, 1);
        check("R2 pulse on wake write", sw_reset_pulse, 1);
        check("R2 fields kept", reg_rdata, 8'h02);

        // R4 collision: power-down write and FIFO access in one cycle
        wr(8'h42, 1);
        check("R4 collision clk_en", clk_en, 1);
        check("R4 collision rdata6", reg_rdata[6], 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule